// File: doc/BRIEF.md
# Reaction Timer with Delayed Start

This block measures how quickly a user reacts to a visual prompt. When the two-bit mode input switches into reaction mode, the block waits a set number of clock cycles, then turns on a prompt LED. From then on, each pulse on a tick-enable input adds one to a four-digit decimal count. A tick typically comes from an external divider, for example once per millisecond. When the user presses stop, the count freezes and stays on display. The wait is either a fixed length or a floor plus a pseudo-random amount taken from a free-running 16-bit LFSR.

A press of stop during the wait is a false start. The block raises a flag and leaves the count at zero. A second mode code runs the same decimal counter as a plain stopwatch with no delay. A manual step input advances the count by one in any mode, and it takes priority over tick-driven counting.

Top module: `rxn_timer`

## Requirements
- R1: While `arst` is high, and right after it is released, all four digits read 0, `prompt_led` is 0 and `false_start` is 0.
- R2: A restart happens on the clock edge at which `mode` is sampled as 2'b10 after it was sampled as something else on the previous edge. A restart clears all digits, the pre-delay count, `prompt_led` and `false_start`. It also wins over `step` in the same cycle.
- R3: With `rand_en` low at the restart edge, the terminal count is `DELAY_CYC`. `prompt_led` rises on the edge that comes `DELAY_CYC`+1 edges after the restart edge. The pre-delay count then holds at its terminal value and does not wrap.
- R4: During the pre-delay wait, `tick` does not change the digits. `prompt_led` is lit only in reaction mode, and it turns off on the first edge at which `mode` is no longer 2'b10.
- R5: In mode 2'b01, or while the prompt is lit and stop has not been pressed, each edge with `tick` high advances the count by exactly one. Edges without `tick` leave it unchanged.
- R6: The count is four BCD digits, with `digit0` least significant. Each digit goes from 9 to 0 and carries into the next digit. 9999 advances to 0000.
- R7: An edge with `step` high advances the count by exactly one in any mode, even when `tick` is also high in the same cycle.
- R8: A `stop` press while the prompt is lit freezes the digits. Later ticks are ignored, and `prompt_led` stays on until the next restart or until reaction mode is left.
- R9: A `stop` press during the wait sets `false_start` on the next edge. The prompt then never lights, and the digits stay at 0 despite ticks until the next restart.
- R10: With `rand_en` high at the restart edge, the terminal count is `MIN_DLY` + (LFSR & (2^`RAND_BITS`−1)), using the LFSR value just before that edge. The LFSR has 16 bits and loads 16'hACE1 on reset. On every edge it shifts right and XORs in 16'hB400 when the bit shifted out was 1.
- R11: In modes 2'b00 and 2'b11, `tick` does not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst | input | 1 | Asynchronous reset, active high |
| mode | input | 2 | 2'b01 stopwatch, 2'b10 reaction, others hold |
| tick | input | 1 | One-cycle count enable (time unit) |
| step | input | 1 | Manual advance by one, highest counting priority |
| stop | input | 1 | User stop button (already debounced) |
| rand_en | input | 1 | Use the random terminal count at the next restart |
| digit0 | output | 4 | BCD units |
| digit1 | output | 4 | BCD tens |
| digit2 | output | 4 | BCD hundreds |
| digit3 | output | 4 | BCD thousands |
| prompt_led | output | 1 | Prompt light, on while the reaction is being timed or is frozen |
| false_start | output | 1 | Stop was pressed before the prompt |

## Verification
The bench counts the edges between the mode change and the prompt, and compares them with the terminal count plus two. This exposes an off-by-one in the edge detector or the saturating compare. Such a design would light the LED one cycle early or late, or never light it if the counter wrapped. Ticks run all through the wait, so a design that counts before the prompt shows a nonzero time. The bench presses stop both before and after the prompt, which catches a frozen count that keeps moving or a false start that lets the LED come on. It drives the count across 9, 99 and 9999, and applies step and tick together, to catch broken carries and double increments. The random terminal count is checked against an independent LFSR model, so a wrong tap, wrong seed or wrong sampling moment changes the measured delay.

// File: rtl/rxn_timer.sv
module rxn_timer #(
  parameter int DELAY_CYC = 50000,
  parameter int MIN_DLY   = 1000,
  parameter int RAND_BITS = 16
) (
  input  logic       clk,
  input  logic       arst,
  input  logic [1:0] mode,
  input  logic       tick,
  input  logic       step,
  input  logic       stop,
  input  logic       rand_en,
  output logic [3:0] digit0,
  output logic [3:0] digit1,
  output logic [3:0] digit2,
  output logic [3:0] digit3,
  output logic       prompt_led,
  output logic       false_start
);

  localparam int RSPAN = 1 << RAND_BITS;
  localparam int TMAX  = (DELAY_CYC > MIN_DLY + RSPAN) ? DELAY_CYC : MIN_DLY + RSPAN;
  localparam int CW    = $clog2(TMAX + 1);
  localparam logic [15:0] RMASK = 16'(RSPAN - 1);
  localparam logic [15:0] SEED  = 16'hACE1;
  localparam logic [15:0] TAPS  = 16'hB400;

  typedef enum logic [2:0] {PH_IDLE, PH_WAIT, PH_RUN, PH_HALT, PH_FOUL} phase_t;

  phase_t        phase;
  logic [1:0]    mode_q;
  logic [CW-1:0] dly_cnt, term;
  logic [15:0]   lfsr, bcd;

  wire in_rxn   = (mode == 2'b10);
  wire restart  = in_rxn && (mode_q != 2'b10);
  wire run_tick = tick && ((mode == 2'b01) || (in_rxn && phase == PH_RUN && !stop));

  function automatic logic [15:0] bcd_next(input logic [15:0] v);
    logic [15:0] r;
    logic        c;
    r = v;
    c = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (c) begin
        if (r[4*i +: 4] >= 4'd9) r[4*i +: 4] = 4'd0;
        else begin
          r[4*i +: 4] = r[4*i +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk or posedge arst) begin
    if (arst) lfsr <= SEED;
    else      lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? TAPS : 16'h0000);
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      mode_q  <= 2'b00;
      phase   <= PH_IDLE;
      dly_cnt <= '0;
      term    <= CW'(DELAY_CYC);
    end else begin
      mode_q <= mode;
      if (restart) begin
        phase   <= PH_WAIT;
        dly_cnt <= '0;
        term    <= rand_en ? CW'(MIN_DLY) + CW'(lfsr & RMASK) : CW'(DELAY_CYC);
      end else if (!in_rxn) begin
        phase <= PH_IDLE;
      end else begin
        case (phase)
          PH_WAIT: begin
            if (stop)                 phase   <= PH_FOUL;
            else if (dly_cnt == term) phase   <= PH_RUN;
            else                      dly_cnt <= dly_cnt + 1'b1;
          end
          PH_RUN:  if (stop) phase <= PH_HALT;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst)                  bcd <= '0;
    else if (restart)          bcd <= '0;
    else if (step || run_tick) bcd <= bcd_next(bcd);
  end

  assign {digit3, digit2, digit1, digit0} = bcd;
  assign prompt_led  = (phase == PH_RUN) || (phase == PH_HALT);
  assign false_start = (phase == PH_FOUL);

  // R4
  led_mode_chk: assert property (@(posedge clk) disable iff (arst)
    prompt_led |-> (mode_q == 2'b10));

  // R3
  dly_sat_chk: assert property (@(posedge clk) disable iff (arst)
    dly_cnt <= term);

  // R6
  bcd_range_chk: assert property (@(posedge clk) disable iff (arst)
    (digit0 <= 4'd9) && (digit1 <= 4'd9) && (digit2 <= 4'd9) && (digit3 <= 4'd9));

  // R2
  restart_clr_chk: assert property (@(posedge clk) disable iff (arst)
    restart |=> (dly_cnt == '0) && !prompt_led && !false_start && (bcd == 16'h0000));

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (arst)
    (phase == PH_HALT && in_rxn && !step) |=> $stable(bcd));

  // R9
  foul_freeze_chk: assert property (@(posedge clk) disable iff (arst)
    (false_start && in_rxn && !step) |=> $stable(bcd) && !prompt_led);

endmodule

// File: tb/rxn_timer_tb_top.sv
`timescale 1ns/1ps
module rxn_timer_tb_top;
  localparam int DLY = 20;
  localparam int MIN = 5;
  localparam int RB  = 6;

  logic clk = 1'b0, arst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic tick = 1'b0, step = 1'b0, stop = 1'b0, rand_en = 1'b0;
  logic [3:0] d0, d1, d2, d3;
  logic led, fs;
  logic [15:0] m_lfsr;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  rxn_timer #(.DELAY_CYC(DLY), .MIN_DLY(MIN), .RAND_BITS(RB)) dut_i (
    .clk(clk), .arst(arst), .mode(mode), .tick(tick), .step(step), .stop(stop),
    .rand_en(rand_en), .digit0(d0), .digit1(d1), .digit2(d2), .digit3(d3),
    .prompt_led(led), .false_start(fs));

  wire [15:0] dig = {d3, d2, d1, d0};

  always_ff @(posedge clk or posedge arst) begin
    if (arst) m_lfsr <= 16'hACE1;
    else      m_lfsr <= {1'b0, m_lfsr[15:1]} ^ (m_lfsr[0] ? 16'hB400 : 16'h0000);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    arst = 1'b1; mode = 2'b00; tick = 0; step = 0; stop = 0; rand_en = 0;
    cyc(); cyc();
    arst = 1'b0;
    cyc();
  endtask

  task automatic measure(output int n);
    n = 0;
    mode = 2'b10;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (led) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 digits in reset", dig, 16'h0000);
    chk("R1 led in reset", led, 0);
    do_reset();
    chk("R1 digits after reset", dig, 16'h0000);
    chk("R1 led/flag after reset", {led, fs}, 2'b00);
  endtask

  task automatic t_stopwatch();
    do_reset();
    mode = 2'b00; tick = 1; repeat (4) cyc();
    chk("R11 mode 00 ignores tick", dig, 16'h0000);
    mode = 2'b11; repeat (4) cyc();
    chk("R11 mode 11 ignores tick", dig, 16'h0000);
    mode = 2'b01; repeat (7) cyc();
    tick = 0; repeat (3) cyc();
    chk("R5 stopwatch hold without tick", dig, 16'h0007);
    tick = 1; repeat (5) cyc(); tick = 0;
    chk("R5 stopwatch count", dig, 16'h0012);
    tick = 1; step = 1; cyc(); tick = 0; step = 0;
    chk("R7 step and tick together", dig, 16'h0013);
    mode = 2'b00; step = 1; cyc(); step = 0;
    chk("R7 step in mode 00", dig, 16'h0014);
  endtask

  task automatic t_bcd();
    do_reset();
    step = 1;
    repeat (9) cyc();
    chk("R6 digit0 at 9", dig, 16'h0009);
    cyc();
    chk("R6 carry to tens", dig, 16'h0010);
    repeat (89) cyc();
    chk("R6 at 99", dig, 16'h0099);
    cyc();
    chk("R6 carry to hundreds", dig, 16'h0100);
    repeat (9899) cyc();
    chk("R6 at 9999", dig, 16'h9999);
    cyc(); step = 0;
    chk("R6 wrap to 0000", dig, 16'h0000);
  endtask

  task automatic t_fixed();
    int n;
    do_reset();
    tick = 1; rand_en = 0;
    measure(n);
    chk("R3 fixed delay edges", n, DLY + 2);
    chk("R4 no count during wait", dig, 16'h0000);
    repeat (37) cyc(); tick = 0;
    chk("R5 reaction count", dig, 16'h0037);
    stop = 1; cyc(); stop = 0;
    tick = 1; repeat (6) cyc(); tick = 0;
    chk("R8 frozen after stop", dig, 16'h0037);
    chk("R8 led held", led, 1);
    mode = 2'b00; cyc();
    chk("R4 led off leaving mode", led, 0);
    chk("R2 digits kept before restart", dig, 16'h0037);
    mode = 2'b10; cyc();
    chk("R2 restart clears digits", dig, 16'h0000);
    chk("R2 restart led off", led, 0);
  endtask

  task automatic t_false();
    do_reset();
    tick = 1; mode = 2'b10;
    repeat (3) cyc();
    stop = 1; cyc(); stop = 0;
    chk("R9 false start flag", fs, 1);
    repeat (DLY + 10) cyc();
    chk("R9 led never lights", led, 0);
    chk("R9 digits stay zero", dig, 16'h0000);
    tick = 0; mode = 2'b00; cyc();
    mode = 2'b10; cyc();
    chk("R2 restart clears flag", fs, 0);
  endtask

  task automatic t_random();
    int n;
    int exp_n;
    do_reset();
    rand_en = 1;
    for (int k = 0; k < 3; k++) begin
      mode = 2'b00; repeat (k + 2) cyc();
      exp_n = MIN + int'(m_lfsr & 16'h003F) + 2;
      measure(n);
      chk("R10 random delay edges", n, exp_n);
    end
    rand_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_stopwatch();
    t_bcd();
    t_fixed();
    t_false();
    t_random();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule